// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects level-sensitive device interrupt lines into two CPU interrupt outputs. Two primary groups of lines (group A and group B) each have a status view and an enable mask. A third, secondary group of lines shares a single status view. Two independent enable masks filter that secondary group, and each filtered result folds into one fixed bit of a primary group. A request on a secondary line reaches the CPU only when its secondary mask bit and the enable bit of the primary bit that carries it are both set. Software then reads the secondary status to find out which line fired.

All masks and status views sit behind a byte-wide register bus with a registered read path. A further write-only register drops the latched requests of two external timers. A timer request is latched on the rising edge of that timer's output pulse. All external inputs pass through a synchronizer chain before use.

Top module: `cascade_irq_ctrl`

Register map, on a 3-bit address: 0 group A status (read-only), 1 group A mask, 2 group B status (read-only), 3 group B mask, 4 secondary status (read-only), 5 secondary mask for cascade 0, 6 secondary mask for cascade 1, 7 timer clear (write-only, reads as zero).

## Requirements
- R1: After reset, all four mask registers read 0, both CPU outputs are 0 and both timer requests are 0.
- R2: A write to address 1, 3, 5 or 6 stores the byte, and a later read of the same address returns it. Read data appears one clock after the address is presented.
- R3: `cpu_irq0` is the OR over bits of (group A status AND group A mask). It is registered, so a line change shows on `cpu_irq0` SYNC_STAGES+1 clocks after the line is sampled.
- R4: `cpu_irq1` is the OR over bits of (group B status AND group B mask), with the same latency as R3.
- R5: Group A status bit MAP0_BIT (7) is the OR of line 7 of group A and any bit of (secondary status AND secondary mask 0). That request reaches `cpu_irq0` only when group A mask bit 7 is set.
- R6: Group B status bit MAP1_BIT (3) is the OR of line 3 of group B and any bit of (secondary status AND secondary mask 1). That request reaches `cpu_irq1` only when group B mask bit 3 is set.
- R7: Reads of addresses 0, 2 and 4 return the synchronized levels of the lines, with the cascade bits of R5 and R6 included.
- R8: Writes to addresses 0, 2 and 4 are ignored. No mask changes and no CPU output changes.
- R9: A rising edge of `timer_pulse[i]` sets `timer_req[i]`. A pulse that stays high does not set the request again after it has been cleared.
- R10: A write to address 7 clears `timer_req[0]` when data bit 0 is 1 and `timer_req[1]` when data bit 1 is 1. Writing 0x03 clears both, and a 0 bit leaves its request unchanged.
- R11: When a clear and a new rising edge reach the same timer in the same cycle, the request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | GW (8) | Write data |
| bus_rdata | output | GW (8) | Registered read data |
| grp_a_lines | input | GW (8) | Group A interrupt lines |
| grp_b_lines | input | GW (8) | Group B interrupt lines |
| sec_lines | input | GW (8) | Secondary (mappable) interrupt lines |
| timer_pulse | input | 2 | Timer output pulses |
| cpu_irq0 | output | 1 | CPU interrupt output for group A |
| cpu_irq1 | output | 1 | CPU interrupt output for group B |
| timer_req | output | 2 | Latched timer requests |

## Verification
The bench builds the block with GW=8, SYNC_STAGES=2, MAP0_BIT=7 and MAP1_BIT=3. These values expose the exact latency from a line edge to a CPU output, so the bench can check that latency to the cycle. They also put the two cascade bits in different primary bit positions, so a swapped cascade shows at the outputs. With two synchronizer stages, the bench can land a timer clear write in the same cycle as the detected edge, which exercises the set-wins rule. Random line and mask patterns are checked against a bench model of the cascade.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int ADDR_W     = 3;
  localparam int NUM_TIMERS = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_GA_STAT  = 3'd0,
    A_GA_MASK  = 3'd1,
    A_GB_STAT  = 3'd2,
    A_GB_MASK  = 3'd3,
    A_SEC_STAT = 3'd4,
    A_SEC_M0   = 3'd5,
    A_SEC_M1   = 3'd6,
    A_TMR_CLR  = 3'd7
  } cic_addr_e;
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cic_tmr_latch.sv
module cic_tmr_latch (
  input  logic clk,
  input  logic rst,
  input  logic pulse_s,
  input  logic clr,
  output logic req
);
  logic prev;
  logic rise;

  assign rise = pulse_s & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      req  <= 1'b0;
    end else begin
      prev <= pulse_s;
      if (rise)     req <= 1'b1;
      else if (clr) req <= 1'b0;
    end
  end

  // R11: a clear coinciding with a new edge leaves the request set
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (rise && clr) |=> req);
  // R10: a clear without an edge drops the request
  p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !rise) |=> !req);
  // R9: an edge always sets the request
  p_edge_sets_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> req);
endmodule

// File: rtl/cic_regs.sv
module cic_regs
  import cic_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [GW-1:0]         bus_wdata,
  input  logic [GW-1:0]         ga_stat,
  input  logic [GW-1:0]         gb_stat,
  input  logic [GW-1:0]         sec_stat,
  output logic [GW-1:0]         ga_mask,
  output logic [GW-1:0]         gb_mask,
  output logic [GW-1:0]         sec_m0,
  output logic [GW-1:0]         sec_m1,
  output logic [GW-1:0]         bus_rdata,
  output logic [NUM_TIMERS-1:0] tmr_clr
);
  cic_addr_e addr;
  assign addr = cic_addr_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ga_mask <= '0;
      gb_mask <= '0;
      sec_m0  <= '0;
      sec_m1  <= '0;
    end else if (bus_wr) begin
      case (addr)
        A_GA_MASK: ga_mask <= bus_wdata;
        A_GB_MASK: gb_mask <= bus_wdata;
        A_SEC_M0:  sec_m0  <= bus_wdata;
        A_SEC_M1:  sec_m1  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (addr)
        A_GA_STAT:  bus_rdata <= ga_stat;
        A_GA_MASK:  bus_rdata <= ga_mask;
        A_GB_STAT:  bus_rdata <= gb_stat;
        A_GB_MASK:  bus_rdata <= gb_mask;
        A_SEC_STAT: bus_rdata <= sec_stat;
        A_SEC_M0:   bus_rdata <= sec_m0;
        A_SEC_M1:   bus_rdata <= sec_m1;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  always_comb begin
    tmr_clr = '0;
    if (bus_wr && addr == A_TMR_CLR) tmr_clr = bus_wdata[NUM_TIMERS-1:0];
  end

  // R1: masks come out of reset cleared
  p_masks_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ga_mask == '0 && gb_mask == '0 && sec_m0 == '0 && sec_m1 == '0));
  // R8: writes to status addresses leave every mask alone
  p_status_ro_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (addr == A_GA_STAT || addr == A_GB_STAT || addr == A_SEC_STAT))
    |=> ($stable(ga_mask) && $stable(gb_mask) && $stable(sec_m0) && $stable(sec_m1)));
  // R2: a mask write is visible the next cycle
  p_mask_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && addr == A_GA_MASK) |=> (ga_mask == $past(bus_wdata)));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int GW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MAP0_BIT    = 7,
  parameter int MAP1_BIT    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [GW-1:0]         bus_wdata,
  output logic [GW-1:0]         bus_rdata,
  input  logic [GW-1:0]         grp_a_lines,
  input  logic [GW-1:0]         grp_b_lines,
  input  logic [GW-1:0]         sec_lines,
  input  logic [NUM_TIMERS-1:0] timer_pulse,
  output logic                  cpu_irq0,
  output logic                  cpu_irq1,
  output logic [NUM_TIMERS-1:0] timer_req
);
  localparam int SW = 3 * GW + NUM_TIMERS;

  logic [SW-1:0]         sync_out;
  logic [GW-1:0]         ga_sync, gb_sync, sec_stat;
  logic [NUM_TIMERS-1:0] tmr_sync, tmr_clr;
  logic [GW-1:0]         ga_stat, gb_stat;
  logic [GW-1:0]         ga_mask, gb_mask, sec_m0, sec_m1;
  logic                  casc0, casc1;

  cic_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({timer_pulse, sec_lines, grp_b_lines, grp_a_lines}),
    .dout (sync_out)
  );

  assign ga_sync  = sync_out[GW-1:0];
  assign gb_sync  = sync_out[2*GW-1:GW];
  assign sec_stat = sync_out[3*GW-1:2*GW];
  assign tmr_sync = sync_out[SW-1:3*GW];

  assign casc0   = |(sec_stat & sec_m0);
  assign casc1   = |(sec_stat & sec_m1);
  assign ga_stat = ga_sync | (GW'(casc0) << MAP0_BIT);
  assign gb_stat = gb_sync | (GW'(casc1) << MAP1_BIT);

  cic_regs #(.GW(GW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ga_stat   (ga_stat),
    .gb_stat   (gb_stat),
    .sec_stat  (sec_stat),
    .ga_mask   (ga_mask),
    .gb_mask   (gb_mask),
    .sec_m0    (sec_m0),
    .sec_m1    (sec_m1),
    .bus_rdata (bus_rdata),
    .tmr_clr   (tmr_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq0 <= 1'b0;
      cpu_irq1 <= 1'b0;
    end else begin
      cpu_irq0 <= |(ga_stat & ga_mask);
      cpu_irq1 <= |(gb_stat & gb_mask);
    end
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    cic_tmr_latch u_latch (
      .clk     (clk),
      .rst     (rst),
      .pulse_s (tmr_sync[t]),
      .clr     (tmr_clr[t]),
      .req     (timer_req[t])
    );
  end

  // R3: group A output follows the masked status one cycle later
  p_irq0_follow_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_irq0 == $past(|(ga_sync & ga_mask) || (casc0 && ga_mask[MAP0_BIT])));
  // R4: group B output follows the masked status one cycle later
  p_irq1_follow_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq1 == $past(|(gb_sync & gb_mask) || (casc1 && gb_mask[MAP1_BIT])));
  // R5: an enabled secondary hit under mask 0 raises cpu_irq0
  p_cascade0_r5: assert property (@(posedge clk) disable iff (rst)
    (|(sec_stat & sec_m0) && ga_mask[MAP0_BIT]) |=> cpu_irq0);
  // R6: an enabled secondary hit under mask 1 raises cpu_irq1
  p_cascade1_r6: assert property (@(posedge clk) disable iff (rst)
    (|(sec_stat & sec_m1) && gb_mask[MAP1_BIT]) |=> cpu_irq1);
  // R1: outputs are low in the first cycle after reset
  p_out_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_irq0 && !cpu_irq1 && timer_req == '0));
endmodule

// File: tb/cascade_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb_top;
  import cic_pkg::*;

  localparam int GW   = 8;
  localparam int SYNC = 2;
  localparam int M0B  = 7;
  localparam int M1B  = 3;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [ADDR_W-1:0]     bus_addr = '0;
  logic                  bus_wr = 1'b0;
  logic [GW-1:0]         bus_wdata = '0;
  logic [GW-1:0]         bus_rdata;
  logic [GW-1:0]         ga = '0, gb = '0, sec = '0;
  logic [NUM_TIMERS-1:0] tpulse = '0;
  logic                  cpu_irq0, cpu_irq1;
  logic [NUM_TIMERS-1:0] treq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [GW-1:0] m_ga, m_gb, m_s0, m_s1;

  always #2 clk = ~clk;

  cascade_irq_ctrl #(.GW(GW), .SYNC_STAGES(SYNC), .MAP0_BIT(M0B), .MAP1_BIT(M1B)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .grp_a_lines(ga), .grp_b_lines(gb), .sec_lines(sec),
    .timer_pulse(tpulse), .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1), .timer_req(treq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [GW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      A_GA_MASK: m_ga = d;
      A_GB_MASK: m_gb = d;
      A_SEC_M0:  m_s0 = d;
      A_SEC_M1:  m_s1 = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [GW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (SYNC + 3) @(negedge clk);
  endtask

  function automatic logic [GW-1:0] exp_ga_stat();
    return ga | ((|(sec & m_s0)) ? GW'(1) << M0B : '0);
  endfunction
  function automatic logic [GW-1:0] exp_gb_stat();
    return gb | ((|(sec & m_s1)) ? GW'(1) << M1B : '0);
  endfunction
  function automatic int exp_irq0();
    return int'(|(exp_ga_stat() & m_ga));
  endfunction
  function automatic int exp_irq1();
    return int'(|(exp_gb_stat() & m_gb));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [GW-1:0] d;
    void'($urandom(32'h5EED_1234));
    m_ga = '0; m_gb = '0; m_s0 = '0; m_s1 = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq0", cpu_irq0, 0);
    chk("R1 irq1", cpu_irq1, 0);
    chk("R1 timer_req", treq, 0);
    rd(A_GA_MASK, d);  chk("R1 ga mask", d, 0);
    rd(A_GB_MASK, d);  chk("R1 gb mask", d, 0);
    rd(A_SEC_M0, d);   chk("R1 sec m0", d, 0);
    rd(A_SEC_M1, d);   chk("R1 sec m1", d, 0);

    // R2 mask write and readback
    wr(A_GA_MASK, 8'hA5); rd(A_GA_MASK, d); chk("R2 ga mask", d, 8'hA5);
    wr(A_GB_MASK, 8'h3C); rd(A_GB_MASK, d); chk("R2 gb mask", d, 8'h3C);
    wr(A_SEC_M0, 8'h81);  rd(A_SEC_M0, d);  chk("R2 sec m0", d, 8'h81);
    wr(A_SEC_M1, 8'h42);  rd(A_SEC_M1, d);  chk("R2 sec m1", d, 8'h42);
    rd(A_TMR_CLR, d); chk("R2 clear reads zero", d, 0);

    // R3 masking and exact latency on group A
    wr(A_GA_MASK, 8'h00); wr(A_GB_MASK, 8'h00); wr(A_SEC_M0, 8'h00); wr(A_SEC_M1, 8'h00);
    ga = 8'hFF; settle();
    chk("R3 masked off", cpu_irq0, 0);
    ga = 8'h00; wr(A_GA_MASK, 8'h10); settle();
    @(negedge clk); ga = 8'h10;
    repeat (SYNC) @(posedge clk);
    @(negedge clk); chk("R3 not before latency", cpu_irq0, 0);
    @(negedge clk); chk("R3 at latency", cpu_irq0, 1);
    ga = 8'h08; settle(); chk("R3 other bit masked", cpu_irq0, 0);
    ga = 8'h00;

    // R4 group B
    wr(A_GB_MASK, 8'h40); gb = 8'h40; settle();
    chk("R4 enabled", cpu_irq1, 1);
    chk("R4 no crosstalk to irq0", cpu_irq0, 0);
    gb = 8'hBF; settle(); chk("R4 masked bits", cpu_irq1, 0);
    gb = 8'h00; wr(A_GB_MASK, 8'h00);

    // R5 cascade 0 into group A bit 7
    wr(A_GA_MASK, 8'h80); wr(A_SEC_M0, 8'h04); sec = 8'h04; settle();
    chk("R5 cascade reaches irq0", cpu_irq0, 1);
    chk("R5 not on irq1", cpu_irq1, 0);
    rd(A_GA_STAT, d); chk("R7 ga status cascade bit", d, 8'h80);
    rd(A_SEC_STAT, d); chk("R7 secondary status", d, 8'h04);
    sec = 8'h08; settle(); chk("R5 sec bit not in mask0", cpu_irq0, 0);
    sec = 8'h04; wr(A_GA_MASK, 8'h7F); settle(); chk("R5 needs primary bit 7", cpu_irq0, 0);
    wr(A_GA_MASK, 8'h00); wr(A_SEC_M0, 8'h00);

    // R6 cascade 1 into group B bit 3
    wr(A_GB_MASK, 8'h08); wr(A_SEC_M1, 8'h20); sec = 8'h20; settle();
    chk("R6 cascade reaches irq1", cpu_irq1, 1);
    chk("R6 not on irq0", cpu_irq0, 0);
    rd(A_GB_STAT, d); chk("R7 gb status cascade bit", d, 8'h08);
    wr(A_SEC_M1, 8'hDF); settle(); chk("R6 masked by mask1", cpu_irq1, 0);
    sec = 8'h00; wr(A_GB_MASK, 8'h00); wr(A_SEC_M1, 8'h00);

    // R7 plain status reads
    ga = 8'h5A; gb = 8'h21; sec = 8'hC3; settle();
    rd(A_GA_STAT, d);  chk("R7 ga status", d, 8'h5A);
    rd(A_GB_STAT, d);  chk("R7 gb status", d, 8'h21);
    rd(A_SEC_STAT, d); chk("R7 sec status", d, 8'hC3);

    // R8 status writes ignored
    wr(A_GA_MASK, 8'h02); wr(A_GB_MASK, 8'h00);
    ga = 8'h00; gb = 8'h00; sec = 8'h00; settle();
    wr(A_GA_STAT, 8'hFF); wr(A_GB_STAT, 8'hFF); wr(A_SEC_STAT, 8'hFF);
    m_ga = 8'h02; m_gb = 8'h00;
    settle();
    rd(A_GA_MASK, d); chk("R8 ga mask kept", d, 8'h02);
    rd(A_GB_MASK, d); chk("R8 gb mask kept", d, 8'h00);
    rd(A_SEC_M0, d);  chk("R8 sec m0 kept", d, 8'h00);
    chk("R8 irq0 unchanged", cpu_irq0, 0);
    chk("R8 irq1 unchanged", cpu_irq1, 0);
    wr(A_GA_MASK, 8'h00);

    // R9 / R10 timers
    tpulse = 2'b01; settle(); chk("R9 timer0 set", treq, 2'b01);
    tpulse = 2'b11; settle(); chk("R9 timer1 set", treq, 2'b11);
    tpulse = 2'b00; settle(); chk("R9 held after pulse falls", treq, 2'b11);
    wr(A_TMR_CLR, 8'h01); @(negedge clk); chk("R10 bit0 clears only t0", treq, 2'b10);
    wr(A_TMR_CLR, 8'h03); @(negedge clk); chk("R10 0x03 clears both", treq, 2'b00);
    tpulse = 2'b10; settle(); chk("R9 rise sets t1", treq, 2'b10);
    wr(A_TMR_CLR, 8'h02); settle(); chk("R9 held level no reset", treq, 2'b00);
    tpulse = 2'b00; settle();

    // R11 set wins over a clear in the same cycle
    tpulse = 2'b01;
    repeat (SYNC) @(posedge clk);
    @(negedge clk); bus_addr = A_TMR_CLR; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R11 set wins", treq[0], 1);
    tpulse = 2'b00; wr(A_TMR_CLR, 8'h03); @(negedge clk);
    chk("R10 cleared after race", treq, 2'b00);

    // Random patterns against the cascade model (R3 R4 R5 R6 R7)
    for (int i = 0; i < 200; i++) begin
      if (i % 4 == 0) begin
        wr(A_GA_MASK, GW'($urandom)); wr(A_GB_MASK, GW'($urandom));
        wr(A_SEC_M0, GW'($urandom & $urandom)); wr(A_SEC_M1, GW'($urandom & $urandom));
      end
      ga  = GW'($urandom & $urandom & $urandom);
      gb  = GW'($urandom & $urandom & $urandom);
      sec = GW'($urandom & $urandom);
      settle();
      chk("R3 R5 random irq0", cpu_irq0, exp_irq0());
      chk("R4 R6 random irq1", cpu_irq1, exp_irq1());
      rd(A_GA_STAT, d); chk("R7 random ga status", d, exp_ga_stat());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule